// File: doc/BRIEF.md
# Recenterable Elastic Store for Jitter Smoothing

This block is a first-in first-out elastic store that lets serial line data pass from a jittery write side to a smoothed read side. Words enter on a write strobe and leave on a read strobe. Both strobes are qualified on one common clock, and the read strobe would normally come from a smoothed clock. The store can sit in the transmit path or in the receive path. The path it does not occupy is wired straight through. When the block is disabled, both paths bypass it.

The usable depth is chosen at run time in steps of sixteen words, up to the full physical memory. A recenter request is given by flipping a control bit in either direction. It moves the read pointer so that the store holds half of the selected depth. Overflow and underflow set sticky flags and recenter the store on their own. Clear returns the pointers and flags to the empty state but leaves the stored words as they are. Status outputs report the fill level, empty, full, overflow and underflow.

Top module: `ja_elastic_store`

## Requirements
- R1: The depth code c (3 bits) selects a usable depth of (c+1)*16 words. The code is latched only on a clear or a recenter, so after a clear with code c, exactly (c+1)*16 writes raise full_o and (c+1)*16-1 writes do not.
- R2: With enable_i low, tx_data_o equals tx_data_i and rx_data_o equals rx_data_i. Both strobes are ignored, so level_o does not change.
- R3: With enable_i high, path_tx_i=1 places the store between tx_data_i and tx_data_o, and rx_data_o follows rx_data_i. With path_tx_i=0 the store sits between rx_data_i and rx_data_o, and tx_data_o follows tx_data_i.
- R4: Each change of recenter_i, 0 to 1 or 1 to 0, sets level_o to half the latched depth on the next clock and clears both error flags. A recenter_i held steady has no effect, and strobes given in a recenter cycle are ignored.
- R5: clear_i high makes level_o 0, empty_o 1, full_o 0 and both error flags 0 on the next clock. It also resets both pointers to word 0.
- R6: Clear leaves the memory contents unchanged. After clear and then one recenter at depth D, reads return the words last written at positions D/2 through D-1.
- R7: Pointers wrap at the selected depth, so data order is kept across the wrap point.
- R8: A write while full with no read in the same cycle discards the word, sets overflow_o and recenters the store to half depth. overflow_o stays set until a clear or a manual recenter.
- R9: A read while empty sets underflow_o, keeps the previous read word on the output and recenters the store to half depth. underflow_o stays set until a clear or a manual recenter.
- R10: level_o (8 bits) counts the stored words. empty_o is high exactly at level 0 and full_o exactly at the latched depth.
- R11: Read data appears on the buffered output one clock after the read strobe, in write order, and holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Puts the store in a data path |
| path_tx_i | input | 1 | 1: transmit path, 0: receive path |
| recenter_i | input | 1 | Recenter request, acts on each change of level |
| depth_code_i | input | 3 | Depth select, (code+1)*16 words |
| clear_i | input | 1 | Resets pointers and flags |
| wr_stb_i | input | 1 | Write strobe |
| rd_stb_i | input | 1 | Read strobe |
| tx_data_i | input | DATA_W | Transmit data in |
| rx_data_i | input | DATA_W | Receive data in |
| tx_data_o | output | DATA_W | Transmit data out |
| rx_data_o | output | DATA_W | Receive data out |
| level_o | output | 8 | Fill level |
| empty_o | output | 1 | Store is empty |
| full_o | output | 1 | Store is at the selected depth |
| overflow_o | output | 1 | Sticky overflow flag |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach is the claim that clear keeps the memory intact. Clear makes the store look empty, so its contents cannot be seen by reading. The stimulus fills a sixteen-word store with a known pattern and then clears it. It then flips the recenter bit, which puts the read pointer at mid-depth behind a write pointer at zero. The next eight reads can only match the upper half of the old pattern if the memory survived. A second hard case is a depth code that changes without a clear. The bench fills the store to the old depth, checks that full rises at the old depth, and then recenters to show the new depth taking effect.

// File: rtl/ja_pkg.sv
package ja_pkg;
  function automatic int unsigned depth_of(input int unsigned code, input int unsigned step);
    return (code + 1) * step;
  endfunction
endpackage

// File: rtl/ja_toggle_det.sv
module ja_toggle_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic toggle_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign toggle_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/ja_ptr_ctrl.sv
module ja_ptr_ctrl #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned STEP   = 16,
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned LVL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              clear_i,
  input  logic              toggle_i,
  input  logic [CODE_W-1:0] depth_code_i,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  output logic              mem_we_o,
  output logic [PTR_W-1:0]  mem_waddr_o,
  output logic              mem_re_o,
  output logic [PTR_W-1:0]  mem_raddr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [LVL_W-1:0]  depth_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  import ja_pkg::*;

  logic [LVL_W-1:0] depth_q, level_q, code_depth, half;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, rc_wr, rc_rd;
  logic             ovf_q, unf_q;
  logic             wr_go, rd_go, is_empty, is_full;
  logic             ovf_evt, unf_evt, do_rc, acc_wr, acc_rd;

  assign code_depth = LVL_W'(depth_of(int'(depth_code_i), STEP));
  assign half       = code_depth >> 1;

  assign wr_go    = enable_i & wr_stb_i;
  assign rd_go    = enable_i & rd_stb_i;
  assign is_empty = (level_q == '0);
  assign is_full  = (level_q == depth_q);

  assign unf_evt = rd_go & is_empty & ~toggle_i;
  assign ovf_evt = wr_go & is_full & ~rd_go & ~toggle_i;
  assign do_rc   = toggle_i | unf_evt | ovf_evt;
  assign acc_wr  = wr_go & ~do_rc & ~clear_i;
  assign acc_rd  = rd_go & ~do_rc & ~clear_i;

  // recenter targets; rebase the write side if the new depth no longer covers it
  always_comb begin
    logic [LVL_W-1:0] wr_ext;
    wr_ext = LVL_W'(wr_ptr_q);
    if (wr_ext >= code_depth) begin
      rc_wr = PTR_W'(half);
      rc_rd = '0;
    end else begin
      rc_wr = wr_ptr_q;
      rc_rd = (wr_ext >= half) ? PTR_W'(wr_ext - half)
                               : PTR_W'(wr_ext + code_depth - half);
    end
  end

  function automatic logic [PTR_W-1:0] inc_ptr(input logic [PTR_W-1:0] p,
                                               input logic [LVL_W-1:0] d);
    return (LVL_W'(p) + LVL_W'(1) == d) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q  <= LVL_W'(STEP);
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else if (clear_i) begin
      depth_q  <= code_depth;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else if (do_rc) begin
      depth_q  <= code_depth;
      wr_ptr_q <= rc_wr;
      rd_ptr_q <= rc_rd;
      level_q  <= half;
      ovf_q    <= toggle_i ? 1'b0 : (ovf_q | ovf_evt);
      unf_q    <= toggle_i ? 1'b0 : (unf_q | unf_evt);
    end else begin
      if (acc_wr) wr_ptr_q <= inc_ptr(wr_ptr_q, depth_q);
      if (acc_rd) rd_ptr_q <= inc_ptr(rd_ptr_q, depth_q);
      case ({acc_wr, acc_rd})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign mem_we_o    = acc_wr;
  assign mem_waddr_o = wr_ptr_q;
  assign mem_re_o    = acc_rd;
  assign mem_raddr_o = rd_ptr_q;
  assign level_o     = level_q;
  assign depth_o     = depth_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;
endmodule

// File: rtl/ja_store.sv
module ja_store #(
  parameter int unsigned DATA_W = 1,
  parameter int unsigned WORDS  = 128,
  parameter int unsigned PTR_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  // no reset on the array: clear must leave contents alone
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ja_path_mux.sv
module ja_path_mux #(
  parameter int unsigned DATA_W = 1
) (
  input  logic              enable_i,
  input  logic              path_tx_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic on_tx, on_rx;

  assign on_tx       = enable_i & path_tx_i;
  assign on_rx       = enable_i & ~path_tx_i;
  assign buf_wdata_o = path_tx_i ? tx_data_i : rx_data_i;
  assign tx_data_o   = on_tx ? buf_rdata_i : tx_data_i;
  assign rx_data_o   = on_rx ? buf_rdata_i : rx_data_i;
endmodule

// File: rtl/ja_elastic_store.sv
module ja_elastic_store #(
  parameter int unsigned DATA_W = 1,
  parameter int unsigned STEP   = 16,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              path_tx_i,
  input  logic              recenter_i,
  input  logic [CODE_W-1:0] depth_code_i,
  input  logic              clear_i,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [7:0]        level_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  localparam int unsigned MAX_WORDS = STEP << CODE_W;
  localparam int unsigned PTR_W     = $clog2(MAX_WORDS);
  localparam int unsigned LVL_W     = $clog2(MAX_WORDS + 1);

  logic              rc_toggle;
  logic              mem_we, mem_re;
  logic [PTR_W-1:0]  mem_waddr, mem_raddr;
  logic [DATA_W-1:0] buf_wdata, buf_rdata;
  logic [LVL_W-1:0]  level, cur_depth;

  ja_toggle_det u_tog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (recenter_i),
    .toggle_o (rc_toggle)
  );

  ja_ptr_ctrl #(
    .CODE_W (CODE_W),
    .STEP   (STEP),
    .PTR_W  (PTR_W),
    .LVL_W  (LVL_W)
  ) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .clear_i      (clear_i),
    .toggle_i     (rc_toggle),
    .depth_code_i (depth_code_i),
    .wr_stb_i     (wr_stb_i),
    .rd_stb_i     (rd_stb_i),
    .mem_we_o     (mem_we),
    .mem_waddr_o  (mem_waddr),
    .mem_re_o     (mem_re),
    .mem_raddr_o  (mem_raddr),
    .level_o      (level),
    .depth_o      (cur_depth),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o)
  );

  ja_store #(
    .DATA_W (DATA_W),
    .WORDS  (MAX_WORDS),
    .PTR_W  (PTR_W)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (buf_wdata),
    .re_i    (mem_re),
    .raddr_i (mem_raddr),
    .rdata_o (buf_rdata)
  );

  ja_path_mux #(.DATA_W(DATA_W)) u_mux (
    .enable_i    (enable_i),
    .path_tx_i   (path_tx_i),
    .tx_data_i   (tx_data_i),
    .rx_data_i   (rx_data_i),
    .buf_rdata_i (buf_rdata),
    .buf_wdata_o (buf_wdata),
    .tx_data_o   (tx_data_o),
    .rx_data_o   (rx_data_o)
  );

  assign level_o = 8'(level);
  assign empty_o = (level == '0);
  assign full_o  = (level == cur_depth);
endmodule

// File: rtl/ja_elastic_store_chk.sv
module ja_elastic_store_chk #(
  parameter int unsigned DATA_W = 1,
  parameter int unsigned STEP   = 16,
  parameter int unsigned LVL_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              clear_i,
  input logic              wr_stb_i,
  input logic              rd_stb_i,
  input logic              rc_toggle,
  input logic [LVL_W-1:0]  cur_depth,
  input logic [DATA_W-1:0] buf_rdata,
  input logic [DATA_W-1:0] tx_data_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [7:0]        level_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              overflow_o,
  input logic              underflow_o
);
  p_depth_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_depth % STEP == 0) && (cur_depth != 0));

  p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (tx_data_o == tx_data_i) && (rx_data_o == rx_data_i));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !clear_i && !rc_toggle) |=> $stable(level_o));

  p_recenter_half_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc_toggle && !clear_i) |=> (8'(cur_depth >> 1) == level_o) && !overflow_o && !underflow_o);

  p_clear_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o && !full_o && !overflow_o && !underflow_o);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && wr_stb_i && !rd_stb_i && full_o && !clear_i && !rc_toggle)
      |=> overflow_o && (level_o == 8'(cur_depth >> 1)));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clear_i && !rc_toggle) |=> overflow_o);

  p_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && rd_stb_i && empty_o && !clear_i && !rc_toggle)
      |=> underflow_o && $stable(buf_rdata));

  p_unf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !clear_i && !rc_toggle) |=> underflow_o);

  p_level_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o <= 8'(cur_depth)) && !(full_o && empty_o));

  p_read_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(buf_rdata));
endmodule

bind ja_elastic_store ja_elastic_store_chk #(
  .DATA_W (DATA_W),
  .STEP   (STEP),
  .LVL_W  (LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .clear_i     (clear_i),
  .wr_stb_i    (wr_stb_i),
  .rd_stb_i    (rd_stb_i),
  .rc_toggle   (rc_toggle),
  .cur_depth   (cur_depth),
  .buf_rdata   (buf_rdata),
  .tx_data_i   (tx_data_i),
  .rx_data_i   (rx_data_i),
  .tx_data_o   (tx_data_o),
  .rx_data_o   (rx_data_o),
  .level_o     (level_o),
  .empty_o     (empty_o),
  .full_o      (full_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/ja_elastic_store_tb_top.sv
module ja_elastic_store_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1, path_tx = 1'b0, recenter = 1'b0, clear = 1'b0;
  logic [2:0] code = 3'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic       tx_in = 1'b0, rx_in = 1'b0;
  logic       tx_out, rx_out, empty, full, ovf, unf;
  logic [7:0] level;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ja_elastic_store dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .enable_i     (enable),
    .path_tx_i    (path_tx),
    .recenter_i   (recenter),
    .depth_code_i (code),
    .clear_i      (clear),
    .wr_stb_i     (wr),
    .rd_stb_i     (rd),
    .tx_data_i    (tx_in),
    .rx_data_i    (rx_in),
    .tx_data_o    (tx_out),
    .rx_data_o    (rx_out),
    .level_o      (level),
    .empty_o      (empty),
    .full_o       (full),
    .overflow_o   (ovf),
    .underflow_o  (unf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  function automatic logic pat(input int i);
    return logic'((i * 5 + (i >> 2)) % 3 == 1);
  endfunction

  // inputs change on the falling edge; one rising edge passes per call
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_clear(input logic [2:0] c);
    code = c; clear = 1'b1; tick(); clear = 1'b0;
  endtask

  task automatic flip_recenter();
    recenter = ~recenter; tick();
  endtask

  task automatic put(input logic b);
    if (path_tx) tx_in = b; else rx_in = b;
    wr = 1'b1; tick(); wr = 1'b0;
  endtask

  task automatic get(output logic b);
    rd = 1'b1; tick(); rd = 1'b0;
    b = path_tx ? tx_out : rx_out;
  endtask

  task automatic t_reset();
    chk_eq("R10 reset level", level, 0);
    chk_eq("R10 reset empty", empty, 1);
    chk_eq("R5 reset flags", {ovf, unf}, 0);
  endtask

  task automatic t_depth();
    int codes[3] = '{0, 3, 7};
    foreach (codes[k]) begin
      int d = (codes[k] + 1) * 16;
      do_clear(3'(codes[k]));
      for (int i = 0; i < d - 1; i++) put(pat(i));
      chk_eq("R1 not full at depth-1", full, 0);
      chk_eq("R10 level at depth-1", level, d - 1);
      put(1'b1);
      chk_eq("R1 full at depth", full, 1);
      chk_eq("R10 level at depth", level, d);
    end
  endtask

  task automatic t_order();
    logic b;
    do_clear(3'd0);
    for (int i = 0; i < 10; i++) put(pat(i));
    for (int i = 0; i < 10; i++) begin
      get(b);
      chk_eq("R11 order first pass", b, pat(i));
    end
    chk_eq("R10 empty after drain", empty, 1);
    for (int i = 0; i < 12; i++) put(pat(i + 20));
    for (int i = 0; i < 12; i++) begin
      get(b);
      chk_eq("R7 order across wrap", b, pat(i + 20));
    end
    put(1'b1); put(1'b0);
    get(b);
    chk_eq("R11 one-cycle read", b, 1);
    tick(); tick();
    chk_eq("R11 output held", rx_out, 1);
  endtask

  task automatic t_overflow();
    do_clear(3'd0);
    for (int i = 0; i < 16; i++) put(1'b0);
    put(1'b1);
    chk_eq("R8 overflow set", ovf, 1);
    chk_eq("R8 recentered level", level, 8);
    put(1'b1);
    chk_eq("R8 overflow sticky", ovf, 1);
    chk_eq("R8 level after write", level, 9);
  endtask

  task automatic t_underflow();
    logic b;
    do_clear(3'd0);
    put(1'b1);
    get(b);
    chk_eq("R11 single word", b, 1);
    get(b);
    chk_eq("R9 underflow set", unf, 1);
    chk_eq("R9 word repeated", b, 1);
    chk_eq("R9 recentered level", level, 8);
    tick();
    chk_eq("R9 underflow sticky", unf, 1);
  endtask

  task automatic t_recenter();
    logic b;
    do_clear(3'd1);
    get(b);
    chk_eq("R9 setup flag", unf, 1);
    for (int i = 0; i < 5; i++) put(1'b0);
    chk_eq("R4 level before", level, 21);
    flip_recenter();
    chk_eq("R4 rising recenter level", level, 16);
    chk_eq("R4 flags cleared", {ovf, unf}, 0);
    for (int i = 0; i < 3; i++) put(1'b1);
    tick(); tick();
    chk_eq("R4 steady bit no effect", level, 19);
    flip_recenter();
    chk_eq("R4 falling recenter level", level, 16);
    recenter = ~recenter; wr = 1'b1; tick(); wr = 1'b0;
    chk_eq("R4 strobe ignored in recenter", level, 16);
    code = 3'd2;
    for (int i = 0; i < 16; i++) put(1'b0);
    chk_eq("R1 old depth still applies", full, 1);
    flip_recenter();
    chk_eq("R1 new depth at recenter", level, 24);
    chk_eq("R1 not full at new depth", full, 0);
  endtask

  task automatic t_clear_keeps();
    logic b;
    do_clear(3'd0);
    for (int i = 0; i < 16; i++) put(pat(i + 40));
    do_clear(3'd0);
    chk_eq("R5 clear empties", empty, 1);
    chk_eq("R5 clear level", level, 0);
    flip_recenter();
    chk_eq("R6 recenter after clear", level, 8);
    for (int i = 8; i < 16; i++) begin
      get(b);
      chk_eq("R6 memory kept", b, pat(i + 40));
    end
  endtask

  task automatic t_paths();
    logic b;
    path_tx = 1'b1;
    do_clear(3'd0);
    rx_in = 1'b1; #1;
    chk_eq("R3 rx bypass high", rx_out, 1);
    rx_in = 1'b0; #1;
    chk_eq("R3 rx bypass low", rx_out, 0);
    put(1'b1); put(1'b0); put(1'b1);
    chk_eq("R3 tx buffered level", level, 3);
    get(b); chk_eq("R3 tx word0", b, 1);
    get(b); chk_eq("R3 tx word1", b, 0);
    path_tx = 1'b0;
    tx_in = 1'b1; #1;
    chk_eq("R3 tx bypass when rx buffered", tx_out, 1);
    enable = 1'b0;
    tx_in = 1'b0; rx_in = 1'b1; #1;
    chk_eq("R2 tx bypass", tx_out, 0);
    chk_eq("R2 rx bypass", rx_out, 1);
    wr = 1'b1; rd = 1'b1; tick(); tick(); wr = 1'b0; rd = 1'b0;
    chk_eq("R2 strobes ignored", level, 1);
    enable = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_depth();
    t_order();
    t_overflow();
    t_underflow();
    t_recenter();
    t_clear_keeps();
    t_paths();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end
endmodule